// File: doc/BRIEF.md
# Instruction Pairing Detector

This block watches the retire stream of an instruction sequencer and tells a downstream cycle adjuster when two consecutive instructions form a pair that may overlap. Each retiring instruction arrives as a 7-bit operation-class code together with a retire strobe. The block keeps the class of the last retired instruction. It looks up the ordered pair (earlier class, current class) in a fixed compatibility rule set and raises a registered flag in the cycle after the strobe.

The rule set is ordered and deliberately asymmetric. The whole group of eight shift and rotate classes shares one set of followers. A multiply may be followed by a divide, but a divide may not be followed by a multiply. An add or subtract followed by a plain move pairs only when the sequencer reports, through a qualifier input, that the move uses an indexed-with-displacement address. Decoding instructions into classes and adjusting cycle counts are left to neighbouring blocks.

Top module: `pair_detect`

## Requirements
- R1: After reset `pair_o` is 0 and the stored earlier class is the idle class (code 0), so the first instruction retired after reset never pairs.
- R2: `pair_o` is a registered pulse. It is 1 only in the clock cycle right after a cycle with `retire_i` = 1 whose ordered pair is allowed, and it is 0 in every cycle that follows a cycle without a retire.
- R3: The stored earlier class takes the value of `family_i` on every retire, including retires that do not pair and out-of-range codes. It holds its value across cycles without a retire.
- R4: Any of the shift/rotate classes (codes 8 to 15) followed by move (16), address move (17), effective-address load (18), jump (19), loop-decrement (21) or any of the ALU classes 24 to 35 (add, sub, or, and, xor, invert, clear, negate, extended add, extended sub, decimal add, decimal sub) pairs. The value of `idx_disp_i` has no effect on these pairs.
- R5: Register exchange (40) followed by loop-decrement (21), move (16) or address move (17) pairs.
- R6: Compare (41), address compare (42) or bit test (43) followed by conditional branch (22) pairs.
- R7: Unsigned or signed multiply (48, 49) followed by move (16), address move (17), unsigned or signed divide (50, 51) or subroutine call (20) pairs. Divide followed by multiply does not pair.
- R8: Add (24) or sub (25) followed by move (16) pairs only when `idx_disp_i` = 1 on the retire of the move.
- R9: Every ordered pair not listed in R4 to R8 does not pair. This includes divide then move, move then loop-decrement, branch then compare and shift then shift.
- R10: A code at or above `NUM_CODES` (default 64) never pairs, whether it is the earlier or the current class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| retire_i | input | 1 | One instruction retires in this cycle |
| family_i | input | 7 | Operation-class code of the retiring instruction |
| idx_disp_i | input | 1 | Retiring instruction uses indexed-with-displacement addressing |
| pair_o | output | 1 | Registered flag: the last retire paired with the one before it |

## Verification
Assertions check on every cycle that the flag never appears without a retire in the previous cycle. They also check that the stored class follows each retire and holds otherwise, that out-of-range codes never raise the flag, and that divide-then-multiply and move-then-loop-decrement never pair. The individual allowed entries of the rule set, the effect of the addressing qualifier, and the first instruction after a mid-run reset show up only through the bench's ordered instruction sequences. Each of those sequences carries the class history that makes the next expected flag value what it is.

// File: rtl/pair_detect_pkg.sv
package pair_detect_pkg;

  localparam int FAM_W = 7;
  typedef logic [FAM_W-1:0] fam_t;

  // Operation-class codes
  localparam fam_t C_IDLE       = 7'd0;
  localparam fam_t C_SHIFT_LO   = 7'd8;   // 8..15 shift/rotate group
  localparam fam_t C_SHIFT_HI   = 7'd15;
  localparam fam_t C_MOVE       = 7'd16;
  localparam fam_t C_MOVE_ADDR  = 7'd17;
  localparam fam_t C_LOAD_EA    = 7'd18;
  localparam fam_t C_JUMP       = 7'd19;
  localparam fam_t C_CALL       = 7'd20;
  localparam fam_t C_LOOP_DEC   = 7'd21;
  localparam fam_t C_BRANCH     = 7'd22;
  localparam fam_t C_ALU_LO     = 7'd24;  // 24..35 ALU follower group
  localparam fam_t C_ADD        = 7'd24;
  localparam fam_t C_SUB        = 7'd25;
  localparam fam_t C_ALU_HI     = 7'd35;
  localparam fam_t C_EXCHANGE   = 7'd40;
  localparam fam_t C_COMPARE    = 7'd41;
  localparam fam_t C_COMPARE_A  = 7'd42;
  localparam fam_t C_BIT_TEST   = 7'd43;
  localparam fam_t C_MUL_U      = 7'd48;
  localparam fam_t C_MUL_S      = 7'd49;
  localparam fam_t C_DIV_U      = 7'd50;
  localparam fam_t C_DIV_S      = 7'd51;

  // Class flags used by the rule evaluator
  typedef struct packed {
    logic shift;
    logic exchange;
    logic cmp_like;
    logic mul;
    logic div;
    logic add_sub;
    logic alu_tgt;
    logic move;
    logic move_addr;
    logic load_ea;
    logic jump;
    logic call;
    logic loop_dec;
    logic branch;
  } fam_class_t;

endpackage

// File: rtl/pair_rst_sync.sv
module pair_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/pair_family_class.sv
module pair_family_class
  import pair_detect_pkg::*;
#(
  parameter int NUM_CODES = 64
) (
  input  fam_t       code_i,
  output fam_class_t class_o
);
  logic in_range;

  always_comb begin
    in_range = (int'(code_i) < NUM_CODES);
    class_o  = '0;
    if (in_range) begin
      class_o.shift     = (code_i >= C_SHIFT_LO) && (code_i <= C_SHIFT_HI);
      class_o.alu_tgt   = (code_i >= C_ALU_LO) && (code_i <= C_ALU_HI);
      class_o.add_sub   = (code_i == C_ADD) || (code_i == C_SUB);
      class_o.exchange  = (code_i == C_EXCHANGE);
      class_o.cmp_like  = (code_i == C_COMPARE) || (code_i == C_COMPARE_A) ||
                          (code_i == C_BIT_TEST);
      class_o.mul       = (code_i == C_MUL_U) || (code_i == C_MUL_S);
      class_o.div       = (code_i == C_DIV_U) || (code_i == C_DIV_S);
      class_o.move      = (code_i == C_MOVE);
      class_o.move_addr = (code_i == C_MOVE_ADDR);
      class_o.load_ea   = (code_i == C_LOAD_EA);
      class_o.jump      = (code_i == C_JUMP);
      class_o.call      = (code_i == C_CALL);
      class_o.loop_dec  = (code_i == C_LOOP_DEC);
      class_o.branch    = (code_i == C_BRANCH);
    end
  end
endmodule

// File: rtl/pair_last_family.sv
module pair_last_family
  import pair_detect_pkg::*;
(
  input  logic clk,
  input  logic rst_ns,
  input  logic load_i,
  input  fam_t code_i,
  output fam_t last_o
);
  fam_t last_q;
  fam_t last_d;

  always_comb begin
    last_d = last_q;
    if (load_i) last_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) last_q <= C_IDLE;
    else         last_q <= last_d;
  end

  assign last_o = last_q;

  // R3: stored class follows each retire and holds otherwise
  assert_last_follows_retire_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    load_i |=> (last_o == $past(code_i)));
  assert_last_holds_idle_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    !load_i |=> $stable(last_o));
endmodule

// File: rtl/pair_rule_eval.sv
module pair_rule_eval
  import pair_detect_pkg::*;
(
  input  fam_class_t prev_i,
  input  fam_class_t cur_i,
  input  logic       idx_disp_i,
  output logic       allow_o
);
  logic shift_rule, exch_rule, cmp_rule, mul_rule, addsub_rule;

  always_comb begin
    shift_rule  = prev_i.shift &
                  (cur_i.loop_dec | cur_i.move | cur_i.move_addr |
                   cur_i.load_ea | cur_i.jump | cur_i.alu_tgt);
    exch_rule   = prev_i.exchange & (cur_i.loop_dec | cur_i.move | cur_i.move_addr);
    cmp_rule    = prev_i.cmp_like & cur_i.branch;
    mul_rule    = prev_i.mul & (cur_i.move | cur_i.move_addr | cur_i.div | cur_i.call);
    addsub_rule = prev_i.add_sub & cur_i.move & idx_disp_i;
    allow_o     = shift_rule | exch_rule | cmp_rule | mul_rule | addsub_rule;
  end
endmodule

// File: rtl/pair_detect.sv
module pair_detect
  import pair_detect_pkg::*;
#(
  parameter int NUM_CODES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       retire_i,
  input  logic [6:0] family_i,
  input  logic       idx_disp_i,
  output logic       pair_o
);
  localparam int NUM_PORTS = 2;  // 0: earlier class, 1: current class

  logic       rst_ns;
  fam_t       last_fam;
  fam_t       codes   [NUM_PORTS];
  fam_class_t classes [NUM_PORTS];
  logic       allow;
  logic       pair_q, pair_d;

  pair_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  pair_last_family u_last (
    .clk(clk), .rst_ns(rst_ns), .load_i(retire_i),
    .code_i(family_i), .last_o(last_fam));

  assign codes[0] = last_fam;
  assign codes[1] = family_i;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cls
    pair_family_class #(.NUM_CODES(NUM_CODES)) u_cls (
      .code_i(codes[g]), .class_o(classes[g]));
  end

  pair_rule_eval u_rules (
    .prev_i(classes[0]), .cur_i(classes[1]),
    .idx_disp_i(idx_disp_i), .allow_o(allow));

  always_comb begin
    pair_d = 1'b0;
    if (retire_i) pair_d = allow;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) pair_q <= 1'b0;
    else         pair_q <= pair_d;
  end

  assign pair_o = pair_q;

  // R2: flag only follows a retire
  assert_flag_needs_retire_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    !retire_i |=> !pair_o);
  // R10: out-of-range current code never pairs
  assert_oor_current_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (retire_i && int'(family_i) >= NUM_CODES) |=> !pair_o);
  // R10: out-of-range earlier code never pairs
  assert_oor_earlier_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (retire_i && int'(last_fam) >= NUM_CODES) |=> !pair_o);
  // R7: divide then multiply never pairs
  assert_div_mul_blocked_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (retire_i && (last_fam == C_DIV_U || last_fam == C_DIV_S) &&
     (family_i == C_MUL_U || family_i == C_MUL_S)) |=> !pair_o);
  // R9: move then loop-decrement never pairs
  assert_move_loop_blocked_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (retire_i && last_fam == C_MOVE && family_i == C_LOOP_DEC) |=> !pair_o);
endmodule

// File: tb/sim_pair_detect.sv
module sim_pair_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 1'b0;
  logic [6:0] family_i = 7'd0;
  logic idx_disp_i = 1'b0;
  logic pair_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  pair_detect u0 (.clk(clk), .rst_n(rst_n), .retire_i(retire_i),
                  .family_i(family_i), .idx_disp_i(idx_disp_i), .pair_o(pair_o));

  // entry: {code[12:6], idx[5], expected[4], requirement[3:0]}
  localparam int NV = 40;
  localparam logic [12:0] VEC [NV] = '{
    {7'd16,1'b0,1'b0,4'd1},   // R1 first after reset
    {7'd21,1'b0,1'b0,4'd9},   // R9 move -> loop-dec
    {7'd8 ,1'b0,1'b0,4'd9},
    {7'd21,1'b0,1'b1,4'd4},   // R4 shift -> loop-dec
    {7'd15,1'b0,1'b0,4'd9},
    {7'd24,1'b0,1'b1,4'd4},   // R4 shift -> add
    {7'd16,1'b0,1'b0,4'd8},   // R8 add -> move, no qualifier
    {7'd25,1'b0,1'b0,4'd9},
    {7'd16,1'b1,1'b1,4'd8},   // R8 sub -> move, qualifier
    {7'd40,1'b0,1'b0,4'd9},
    {7'd17,1'b0,1'b1,4'd5},   // R5 exchange -> move addr
    {7'd11,1'b0,1'b0,4'd9},
    {7'd35,1'b1,1'b1,4'd4},   // R4 qualifier ignored
    {7'd41,1'b0,1'b0,4'd9},
    {7'd22,1'b0,1'b1,4'd6},   // R6 compare -> branch
    {7'd41,1'b0,1'b0,4'd9},   // R9 branch -> compare
    {7'd43,1'b0,1'b0,4'd9},
    {7'd22,1'b0,1'b1,4'd6},   // R6 bit test -> branch
    {7'd42,1'b0,1'b0,4'd9},
    {7'd22,1'b0,1'b1,4'd6},   // R6 addr compare -> branch
    {7'd48,1'b0,1'b0,4'd9},
    {7'd51,1'b0,1'b1,4'd7},   // R7 mul -> div
    {7'd49,1'b0,1'b0,4'd7},   // R7 div -> mul blocked
    {7'd20,1'b0,1'b1,4'd7},   // R7 mul -> call
    {7'd50,1'b0,1'b0,4'd9},
    {7'd16,1'b1,1'b0,4'd9},   // R9 div -> move
    {7'd49,1'b0,1'b0,4'd9},
    {7'd16,1'b0,1'b1,4'd7},   // R7 mul -> move
    {7'd12,1'b0,1'b0,4'd9},
    {7'd19,1'b0,1'b1,4'd4},   // R4 shift -> jump
    {7'd13,1'b0,1'b0,4'd9},
    {7'd18,1'b0,1'b1,4'd4},   // R4 shift -> load ea
    {7'd40,1'b0,1'b0,4'd9},
    {7'd21,1'b0,1'b1,4'd5},   // R5 exchange -> loop-dec
    {7'd100,1'b0,1'b0,4'd10}, // R10 out-of-range current
    {7'd16,1'b0,1'b0,4'd10},  // R10 out-of-range earlier
    {7'd9 ,1'b0,1'b0,4'd9},
    {7'd10,1'b0,1'b0,4'd9},   // R9 shift -> shift
    {7'd64,1'b0,1'b0,4'd10},  // R10 boundary code
    {7'd17,1'b0,1'b0,4'd10}
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (pair_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: pair_o=%b expected=%b", req, what, pair_o, exp);
    end
  endtask

  // retire one instruction; flag sampled 1 time unit after the capturing edge
  task automatic retire(input logic [6:0] fam, input logic idx,
                        input logic exp, input int req, input string what);
    @(negedge clk);
    retire_i = 1'b1; family_i = fam; idx_disp_i = idx;
    @(posedge clk); #1;
    retire_i = 1'b0; idx_disp_i = 1'b0;
    check(exp, req, what);
  endtask

  task automatic idle_check(input int req, input string what);
    @(posedge clk); #1;
    check(1'b0, req, what);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; retire_i = 1'b0;
    repeat (2) @(posedge clk);
    #1 check(1'b0, 1, "flag during reset (R1)");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++)
      retire(VEC[i][12:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), "vector");

    // R2: pulse drops when no retire follows
    retire(7'd14, 1'b0, 1'b0, 9, "setup");
    retire(7'd26, 1'b0, 1'b1, 4, "shift -> or (R4)");
    idle_check(2, "no retire after pair (R2)");

    // R3: earlier class held across idle cycles
    retire(7'd10, 1'b0, 1'b0, 9, "setup");
    repeat (3) idle_check(2, "idle cycles (R2)");
    retire(7'd16, 1'b0, 1'b1, 3, "held shift then move (R3)");

    // R3: non-pairing retire still overwrites
    retire(7'd8, 1'b0, 1'b0, 9, "setup");
    retire(7'd22, 1'b0, 1'b0, 9, "shift -> branch (R9)");
    retire(7'd16, 1'b0, 1'b0, 3, "stored class replaced (R3)");

    // R1: mid-run reset clears earlier class
    retire(7'd8, 1'b0, 1'b0, 9, "setup");
    do_reset();
    retire(7'd16, 1'b0, 1'b0, 1, "first after reset (R1)");
    retire(7'd40, 1'b0, 1'b0, 9, "setup");
    retire(7'd16, 1'b0, 1'b1, 5, "exchange -> move (R5)");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule